// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Controller

This block sits next to a small 8-bit processor core and decides, at each instruction boundary, whether the core should take an interrupt and where execution should go. It watches five request lines:

- a non-maskable trap,
- three restart requests that have fixed vectors,
- one general request that is not vectored.

The sources are conditioned in different ways. The trap needs a rising edge followed by a held high level. One restart request is captured by an edge latch. The other two restart requests and the general request are plain level inputs.

The core pulses an enable strobe and a disable strobe to drive a global interrupt-enable flag. A mask-write strobe loads three per-source mask bits and can also clear the edge latch. When a request wins at a boundary, the block pulses `take` one cycle later.

- For a vectored source, it presents the 16-bit handler address at the same time.
- For the general request, it instead pulses an acknowledge. It then waits for the device to place a restart opcode on the data bus, and turns that opcode into an address in page zero.

A pending word shows which raw requests are present.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, `take`, `inta` and `vec_valid` are 0, `ie_flag` is 0, `pending` is 0 when all requests are low, and all three mask bits are set, so level restart requests are blocked.
- R2: `ie_set` sets `ie_flag` on the next cycle and `ie_clr` clears it. When both are high in the same cycle, the flag ends up clear.
- R3: Accepting any source other than the trap clears `ie_flag` on the same edge that raises `take`, even if `ie_set` is high in that cycle.
- R4: The trap is taken whatever the state of `ie_flag` and the masks, with vector 0024h, and acceptance leaves `ie_flag` unchanged. Once it has been serviced, a level that stays high without a new rising edge is not taken again.
- R5: A trap edge whose level falls again before the boundary is not taken.
- R6: A rising edge on `req_r75` sets a latch that holds the request after the input falls. Servicing it (vector 003Ch) clears the latch.
- R7: `mask_wr` loads `mask_bits` (bit 0 blocks `req_r55`, bit 1 blocks `req_r65`, bit 2 blocks the latched `req_r75`, 1 = blocked). When `mask_clr75` is high together with `mask_wr`, the `req_r75` latch is cleared.
- R8: `req_r65` and `req_r55` are level inputs. Each is taken only while it is high, unmasked and `ie_flag` is 1, with vectors 0034h and 002Ch.
- R9: The priority order is fixed, highest first: trap, r75, r65, r55, general.
- R10: Accepting the general request pulses `take` and `inta` for one cycle with `vec_valid` low. Boundaries are then ignored until `opc_valid` brings a byte of the form 11nnn111; bytes of any other form are ignored. One cycle later `vec_valid` pulses with `vec_addr` = nnn × 8.
- R11: `take` rises only in the cycle after a cycle in which `at_boundary` was high. A request that is not accompanied by a boundary is never taken.
- R12: The pending word has this layout: bit 4 is trap latch and level, bit 3 is the r75 latch, bit 2 is `req_r65`, bit 1 is `req_r55`, bit 0 is `req_gen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_trap | input | 1 | Non-maskable trap request (edge and level) |
| req_r75 | input | 1 | Edge-latched restart request, vector 003Ch |
| req_r65 | input | 1 | Level restart request, vector 0034h |
| req_r55 | input | 1 | Level restart request, vector 002Ch |
| req_gen | input | 1 | General non-vectored level request |
| at_boundary | input | 1 | Current instruction has completed |
| ie_set | input | 1 | Enable-flag set strobe |
| ie_clr | input | 1 | Enable-flag clear strobe |
| mask_wr | input | 1 | Load mask bits strobe |
| mask_bits | input | 3 | New mask values (1 = blocked) |
| mask_clr75 | input | 1 | Clear r75 latch with this mask write |
| opc_valid | input | 1 | Restart opcode present on data bus |
| opc_byte | input | 8 | Data bus byte during acknowledge |
| take | output | 1 | One-cycle pulse: core enters interrupt |
| inta | output | 1 | Acknowledge pulse for the general request |
| vec_valid | output | 1 | `vec_addr` holds a new handler address |
| vec_addr | output | 16 | Handler address |
| pending | output | 5 | Raw request status word |
| ie_flag | output | 1 | Global interrupt-enable flag |

## Verification
The bench builds the block with its default vector parameters: 0024h, 003Ch, 0034h and 002Ch on a 16-bit address. This lets it compare every handler address directly against those four values and against restart numbers 0, 3 and 5. With the 8-bit opcode width it can also present both a malformed byte and well-formed restart opcodes during the acknowledge wait. The scenarios stack sources in the same cycle to walk down the priority chain, and they show the effect of the enable flag clearing after each maskable acceptance.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int ADDR_W = 16;
    localparam int OPC_W  = 8;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_TRAP,
        SRC_R75,
        SRC_R65,
        SRC_R55,
        SRC_GEN
    } src_e;

    // Packed so that it maps bit for bit onto the pending word.
    typedef struct packed {
        logic trap;
        logic r75;
        logic r65;
        logic r55;
        logic gen;
    } req_t;

    // A restart number n lands at n * 8 inside page zero.
    function automatic logic [ADDR_W-1:0] restart_addr(input logic [2:0] num);
        return {{(ADDR_W-6){1'b0}}, num, 3'b000};
    endfunction

    // Opcode form 11nnn111.
    function automatic logic is_restart_opc(input logic [OPC_W-1:0] b);
        return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter bit LEVEL_QUAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic lat_q;
    logic rise;

    assign rise = req & ~prev_q;

    generate
        if (LEVEL_QUAL) begin : g_level
            // Edge arms the latch; the level must still be high to count,
            // and a drop of the level disarms it.
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= req;
                    lat_q  <= 1'b0;
                end else begin
                    prev_q <= req;
                    if (rise)
                        lat_q <= 1'b1;
                    else if (clr || !req)
                        lat_q <= 1'b0;
                end
            end
            assign pend = lat_q & req;

            a_r5_low_disarms: assert property (@(posedge clk) disable iff (rst)
                (!req && !rise) |=> !lat_q);
        end else begin : g_edge
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= req;
                    lat_q  <= 1'b0;
                end else begin
                    prev_q <= req;
                    if (rise)
                        lat_q <= 1'b1;
                    else if (clr)
                        lat_q <= 1'b0;
                end
            end
            assign pend = lat_q;

            a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst)
                (lat_q && !clr) |=> lat_q);
        end
    endgenerate

    a_r6_rise_arms: assert property (@(posedge clk) disable iff (rst)
        rise |=> lat_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_prio_pkg::*;
(
    input  req_t elig,
    output src_e win
);
    always_comb begin
        if (elig.trap)      win = SRC_TRAP;
        else if (elig.r75)  win = SRC_R75;
        else if (elig.r65)  win = SRC_R65;
        else if (elig.r55)  win = SRC_R55;
        else if (elig.gen)  win = SRC_GEN;
        else                win = SRC_NONE;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_TRAP = 16'h0024,
    parameter logic [ADDR_W-1:0] VEC_R75  = 16'h003C,
    parameter logic [ADDR_W-1:0] VEC_R65  = 16'h0034,
    parameter logic [ADDR_W-1:0] VEC_R55  = 16'h002C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_trap,
    input  logic              req_r75,
    input  logic              req_r65,
    input  logic              req_r55,
    input  logic              req_gen,
    input  logic              at_boundary,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              mask_wr,
    input  logic [2:0]        mask_bits,
    input  logic              mask_clr75,
    input  logic              opc_valid,
    input  logic [OPC_W-1:0]  opc_byte,
    output logic              take,
    output logic              inta,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [4:0]        pending,
    output logic              ie_flag
);
    localparam int M_R55 = 0;
    localparam int M_R65 = 1;
    localparam int M_R75 = 2;

    logic              ie_q;
    logic [2:0]        mask_q;
    logic              busy_q;
    logic              take_q;
    logic              inta_q;
    logic              vv_q;
    logic [ADDR_W-1:0] vec_q;

    logic trap_pend;
    logic r75_pend;
    logic svc_trap;
    logic svc_r75;
    logic clr75;
    logic accept;
    logic opc_ok;
    req_t elig;
    req_t raw;
    src_e win;

    function automatic logic [ADDR_W-1:0] src_vec(input src_e s);
        case (s)
            SRC_TRAP: return VEC_TRAP;
            SRC_R75:  return VEC_R75;
            SRC_R65:  return VEC_R65;
            SRC_R55:  return VEC_R55;
            default:  return '0;
        endcase
    endfunction

    irq_edge_latch #(.LEVEL_QUAL(1'b1)) u_trap (
        .clk  (clk),
        .rst  (rst),
        .req  (req_trap),
        .clr  (svc_trap),
        .pend (trap_pend)
    );

    irq_edge_latch #(.LEVEL_QUAL(1'b0)) u_r75 (
        .clk  (clk),
        .rst  (rst),
        .req  (req_r75),
        .clr  (clr75),
        .pend (r75_pend)
    );

    always_comb begin
        elig.trap = trap_pend;
        elig.r75  = r75_pend & ~mask_q[M_R75] & ie_q;
        elig.r65  = req_r65  & ~mask_q[M_R65] & ie_q;
        elig.r55  = req_r55  & ~mask_q[M_R55] & ie_q;
        elig.gen  = req_gen  & ie_q;
    end

    irq_prio_pick u_pick (
        .elig (elig),
        .win  (win)
    );

    assign accept   = at_boundary & ~busy_q & (win != SRC_NONE);
    assign svc_trap = accept & (win == SRC_TRAP);
    assign svc_r75  = accept & (win == SRC_R75);
    assign clr75    = svc_r75 | (mask_wr & mask_clr75);
    assign opc_ok   = busy_q & opc_valid & is_restart_opc(opc_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
            busy_q <= 1'b0;
            take_q <= 1'b0;
            inta_q <= 1'b0;
            vv_q   <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= accept;
            inta_q <= accept && (win == SRC_GEN);
            vv_q   <= 1'b0;
            if (accept && (win != SRC_GEN)) begin
                vv_q  <= 1'b1;
                vec_q <= src_vec(win);
            end
            if (opc_ok) begin
                vv_q  <= 1'b1;
                vec_q <= restart_addr(opc_byte[5:3]);
            end
            if (accept && (win == SRC_GEN))
                busy_q <= 1'b1;
            else if (opc_ok)
                busy_q <= 1'b0;
            if (accept && (win != SRC_TRAP))
                ie_q <= 1'b0;
            else if (ie_clr)
                ie_q <= 1'b0;
            else if (ie_set)
                ie_q <= 1'b1;
            if (mask_wr)
                mask_q <= mask_bits;
        end
    end

    always_comb begin
        raw.trap = trap_pend;
        raw.r75  = r75_pend;
        raw.r65  = req_r65;
        raw.r55  = req_r55;
        raw.gen  = req_gen;
    end

    assign pending   = raw;
    assign take      = take_q;
    assign inta      = inta_q;
    assign vec_valid = vv_q;
    assign vec_addr  = vec_q;
    assign ie_flag   = ie_q;

    a_r11_take_after_boundary: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(at_boundary));

    a_r3_ie_dropped: assert property (@(posedge clk) disable iff (rst)
        (accept && win != SRC_TRAP) |=> (take && !ie_flag));

    a_r4_trap_keeps_ie: assert property (@(posedge clk) disable iff (rst)
        (svc_trap && ie_q && !ie_clr) |=> ie_flag);

    a_r9_trap_first: assert property (@(posedge clk) disable iff (rst)
        (win != SRC_TRAP && win != SRC_NONE) |-> !trap_pend);

    a_r10_inta_single: assert property (@(posedge clk) disable iff (rst)
        inta |=> !inta);

    a_r10_inta_no_vector: assert property (@(posedge clk) disable iff (rst)
        inta |-> (take && !vec_valid));

    a_r10_wait_blocks: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !take);

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic        req_trap;
    logic        req_r75;
    logic        req_r65;
    logic        req_r55;
    logic        req_gen;
    logic        at_boundary;
    logic        ie_set;
    logic        ie_clr;
    logic        mask_wr;
    logic [2:0]  mask_bits;
    logic        mask_clr75;
    logic        opc_valid;
    logic [7:0]  opc_byte;
    logic        take;
    logic        inta;
    logic        vec_valid;
    logic [15:0] vec_addr;
    logic [4:0]  pending;
    logic        ie_flag;

    irq_prio_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .req_trap    (req_trap),
        .req_r75     (req_r75),
        .req_r65     (req_r65),
        .req_r55     (req_r55),
        .req_gen     (req_gen),
        .at_boundary (at_boundary),
        .ie_set      (ie_set),
        .ie_clr      (ie_clr),
        .mask_wr     (mask_wr),
        .mask_bits   (mask_bits),
        .mask_clr75  (mask_clr75),
        .opc_valid   (opc_valid),
        .opc_byte    (opc_byte),
        .take        (take),
        .inta        (inta),
        .vec_valid   (vec_valid),
        .vec_addr    (vec_addr),
        .pending     (pending),
        .ie_flag     (ie_flag)
    );

    // kind 0: vectored take, 1: acknowledge take, 2: resolved restart vector
    typedef struct {
        int          kind;
        logic [15:0] addr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [15:0] addr, input string tag);
        exp_t e;
        e.kind = kind;
        e.addr = addr;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: pops the scoreboard whenever the design reports an event.
    always @(negedge clk) begin
        if (!rst && (take || vec_valid)) begin
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected event actual=%b%b%b/%h expected=none",
                         take, inta, vec_valid, vec_addr);
            end else begin
                exp_t e;
                logic [18:0] a;
                logic [18:0] x;
                e = q.pop_front();
                a = {take, inta, vec_valid, (vec_valid ? vec_addr : 16'h0000)};
                x = {(e.kind != 2), (e.kind == 1), (e.kind != 1),
                     ((e.kind != 1) ? e.addr : 16'h0000)};
                if (a !== x) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, a, x);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bnd();
        at_boundary = 1'b1;
        step();
        at_boundary = 1'b0;
    endtask

    task automatic enable();
        ie_set = 1'b1;
        step();
        ie_set = 1'b0;
    endtask

    task automatic load_mask(input logic [2:0] m, input logic c75);
        mask_wr    = 1'b1;
        mask_bits  = m;
        mask_clr75 = c75;
        step();
        mask_wr    = 1'b0;
        mask_clr75 = 1'b0;
    endtask

    task automatic opc(input logic [7:0] b);
        opc_valid = 1'b1;
        opc_byte  = b;
        step();
        opc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        {req_trap, req_r75, req_r65, req_r55, req_gen} = '0;
        {at_boundary, ie_set, ie_clr, mask_wr, mask_clr75, opc_valid} = '0;
        mask_bits = 3'b000;
        opc_byte  = 8'h00;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 take",   {31'd0, take}, 32'd0);
        chk("R1 inta",   {31'd0, inta}, 32'd0);
        chk("R1 vvalid", {31'd0, vec_valid}, 32'd0);
        chk("R1 ie",     {31'd0, ie_flag}, 32'd0);
        chk("R1 pending", {27'd0, pending}, 32'd0);

        // R2 enable flag strobes
        enable();
        chk("R2 set", {31'd0, ie_flag}, 32'd1);
        ie_clr = 1'b1; step(); ie_clr = 1'b0;
        chk("R2 clr", {31'd0, ie_flag}, 32'd0);
        ie_set = 1'b1; ie_clr = 1'b1; step(); ie_set = 1'b0; ie_clr = 1'b0;
        chk("R2 both", {31'd0, ie_flag}, 32'd0);

        // R1 masks start set: level request blocked
        enable();
        req_r55 = 1'b1;
        step();
        chk("R12 r55 pending", {27'd0, pending}, 32'h02);
        bnd();
        chk("R1 masked no take", {31'd0, take}, 32'd0);

        // R7 unmask, R8 level r55, R3 ie dropped
        load_mask(3'b000, 1'b0);
        ie_set = 1'b1;
        push(0, 16'h002C, "R8 r55 vector");
        at_boundary = 1'b1; step(); at_boundary = 1'b0; ie_set = 1'b0;
        chk("R3 ie cleared", {31'd0, ie_flag}, 32'd0);
        step();

        // R11 no take without boundary
        enable();
        repeat (3) step();
        chk("R11 no boundary", {31'd0, take}, 32'd0);

        // R9 r65 over r55, R8 then level only
        req_r65 = 1'b1;
        push(0, 16'h0034, "R9 r65 over r55");
        bnd();
        step();
        bnd();
        chk("R8 ie low no take", {31'd0, take}, 32'd0);
        req_r65 = 1'b0;
        enable();
        push(0, 16'h002C, "R8 r55 after r65 drop");
        bnd();
        req_r55 = 1'b0;
        step();

        // R6 r75 edge latch
        req_r75 = 1'b1; step(); req_r75 = 1'b0;
        step();
        chk("R6 latch held", {27'd0, pending}, 32'h08);
        enable();
        push(0, 16'h003C, "R6 r75 vector");
        bnd();
        chk("R6 latch cleared", {27'd0, pending}, 32'h00);
        step();

        // R7 mask-write clears the latch
        req_r75 = 1'b1; step(); req_r75 = 1'b0;
        chk("R7 latch set", {27'd0, pending}, 32'h08);
        load_mask(3'b000, 1'b1);
        chk("R7 latch cleared", {27'd0, pending}, 32'h00);
        enable();
        bnd();
        chk("R7 no take after clear", {31'd0, take}, 32'd0);

        // R7 mask bit 2 blocks r75
        load_mask(3'b100, 1'b0);
        req_r75 = 1'b1; step(); req_r75 = 1'b0;
        bnd();
        chk("R7 r75 masked", {31'd0, take}, 32'd0);
        load_mask(3'b100, 1'b1);

        // R4 trap ignores ie and masks
        load_mask(3'b111, 1'b0);
        ie_clr = 1'b1; step(); ie_clr = 1'b0;
        req_trap = 1'b1; step();
        chk("R12 trap pending", {27'd0, pending}, 32'h10);
        push(0, 16'h0024, "R4 trap with ie low");
        bnd();
        step();
        bnd();
        chk("R4 held level no retake", {31'd0, take}, 32'd0);
        req_trap = 1'b0;
        step();

        // R5 edge then drop before boundary
        req_trap = 1'b1; step(); req_trap = 1'b0; step();
        bnd();
        chk("R5 dropped trap", {31'd0, take}, 32'd0);

        // R9 full priority chain, R4 ie kept by trap
        load_mask(3'b000, 1'b0);
        enable();
        req_trap = 1'b1; req_r75 = 1'b1; req_r65 = 1'b1; req_gen = 1'b1;
        step();
        req_r75 = 1'b0;
        chk("R12 pending mix", {27'd0, pending}, 32'h1D);
        push(0, 16'h0024, "R9 trap first");
        bnd();
        chk("R4 ie kept", {31'd0, ie_flag}, 32'd1);
        step();
        push(0, 16'h003C, "R9 r75 second");
        bnd();
        step();
        enable();
        push(0, 16'h0034, "R9 r65 third");
        bnd();
        req_r65 = 1'b0;
        req_trap = 1'b0;
        step();
        enable();
        push(1, 16'h0000, "R10 general acknowledge");
        bnd();
        req_gen = 1'b0;
        step();
        push(2, 16'h0018, "R10 restart 3");
        opc(8'hDF);
        step();

        // R10 wait blocks boundaries, bad byte ignored
        req_gen = 1'b1;
        enable();
        push(1, 16'h0000, "R10 acknowledge again");
        bnd();
        req_gen = 1'b0;
        step();
        enable();
        req_r55 = 1'b1;
        bnd();
        chk("R10 busy ignores boundary", {31'd0, take}, 32'd0);
        opc(8'h00);
        chk("R10 bad byte ignored", {31'd0, vec_valid}, 32'd0);
        push(2, 16'h0028, "R10 restart 5");
        opc(8'hEF);
        step();
        push(0, 16'h002C, "R10 released to r55");
        bnd();
        req_r55 = 1'b0;
        step();

        // R10 restart 0
        req_gen = 1'b1;
        enable();
        push(1, 16'h0000, "R10 acknowledge third");
        bnd();
        req_gen = 1'b0;
        push(2, 16'h0000, "R10 restart 0");
        opc(8'hC7);
        repeat (2) step();

        chk("R10 scoreboard drained", q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule